// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block is the hardware half of a receive descriptor ring kept in shared memory. The host builds a ring of 2^n entries of 16 bytes each. Every entry holds a buffer pointer, a status word, a message-count word and a spare word for software. The host marks each entry as owned by the hardware. When a frame starts to arrive, the engine reads the status word of the current entry. If the engine does not own that entry, the frame is thrown away and a missed-frame pulse is raised. Otherwise the engine reads the buffer pointer and streams the frame bytes into the buffer, packed four to a word. It then writes back the received length, followed by the status word with ownership returned to the host. Finally it pulses a receive interrupt and moves to the next entry, wrapping at the end of the ring.

The buffer capacity is taken from the low half of the status word, stored there as a negative 16-bit count. Bytes beyond that capacity are never written, and the overflow flag marks the frame. The stored length counts every byte of the frame, including its four check-sequence bytes. Two error flags from the receiver are folded into the written status: a bad check sequence and a framing fault. Checking the check sequence itself and filtering addresses happen upstream of this block.

The memory port is synchronous. A write completes in the cycle it is requested, and read data appears one cycle after the request. All addresses are byte addresses. The ring base and every buffer pointer must be aligned: the base to 16 bytes, each buffer pointer to 4 bytes.

Top module: `rx_ring_engine`

## Requirements
- R1: After reset the engine makes no memory request, holds `rx_ready` low, raises neither pulse, and uses ring entry 0.
- R2: For a frame, the engine reads the status word at entry address + 4 and then the buffer pointer at entry address + 0, where entry address = `ring_base` + 16 × index.
- R3: If bit 31 (ownership) of the status word read is 0, the engine consumes the whole frame without any memory write. It pulses `rx_missed` for one cycle, raises no `rx_int`, and keeps the same ring index for the next frame.
- R4: Frame byte i goes to buffer pointer + i, little-endian within each 32-bit word (byte 4m+k on lane k, bits 8k+7:8k). Bytes at an offset of at least the capacity are never written. The capacity is the two's-complement negation of status bits 15:0.
- R5: Status bit 28 (overflow) is written as 1 exactly when the frame length exceeds the capacity.
- R6: The word at entry + 8 is written with the total frame byte count, check bytes included, in bits 11:0, and zeros in bits 31:12.
- R7: The written-back status word has bit 31 = 0, bit 25 (start) = 1 and bit 24 (end) = 1. It has bit 27 = the check-sequence error flag, bit 29 = the framing flag and bit 26 (buffer error) = 0. Bit 30 is the OR of bits 26 to 29. Bits 23:16 are 0, and bits 15:0 are unchanged from the word that was read.
- R8: The status write-back happens in the cycle right after the message-count write.
- R9: After each completed frame the index advances by one modulo 2^n. Here n is `ring_log2` (bits 7:4 of the host's length byte), limited to `MAX_LOG`.
- R10: `rx_int` is a single-cycle pulse that coincides with the status write-back of each completed frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | AW | Byte address of ring entry 0, 16-byte aligned |
| ring_log2 | input | 4 | Log2 of the ring entry count |
| rx_valid | input | 1 | A frame byte is present |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | This byte ends the frame |
| rx_crc_bad | input | 1 | Check sequence wrong, sampled with the last byte |
| rx_fram_bad | input | 1 | Framing fault, sampled with the last byte |
| rx_ready | output | 1 | Byte accepted on this edge if `rx_valid` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables for writes |
| mem_rdata | input | 32 | Read data, one cycle after a read request |
| rx_int | output | 1 | Frame-complete pulse |
| rx_missed | output | 1 | Frame dropped, entry not owned |

## Verification
The bench sweeps frame lengths of 1 to 12 bytes against capacities of 5 and 8 bytes, so the capacity edge falls in the middle of a word and also on a word boundary. Guard bytes after each buffer expose a design that writes past its capacity or masks lanes wrongly. Error-flag combinations and a wrongly placed or ordered length write show up in the descriptor words read back. An entry the engine does not own must leave memory untouched and leave the index where it was; a design that advanced anyway would put the next frame into the wrong entry. A second run with a two-entry ring catches a wrap that ignores `ring_log2`.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_STAT_RD, S_PTR_RD, S_DATA, S_LEN_WR, S_STAT_WR, S_DROP
    } rxr_state_e;

    localparam int OWN_BIT  = 31;
    localparam int ERR_BIT  = 30;
    localparam int FRAM_BIT = 29;
    localparam int OFLO_BIT = 28;
    localparam int CRC_BIT  = 27;
    localparam int BUFE_BIT = 26;
    localparam int STP_BIT  = 25;
    localparam int ENP_BIT  = 24;
endpackage

// File: rtl/rxr_index.sv
module rxr_index #(
    parameter int MAX_LOG = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adv,
    input  logic [3:0]         log2,
    output logic [MAX_LOG-1:0] idx
);
    localparam int IW = MAX_LOG;

    logic [IW-1:0] idx_d, idx_q;
    logic [3:0]    n_eff;
    logic [IW:0]   span;

    always_comb begin
        n_eff = (log2 > 4'(MAX_LOG)) ? 4'(MAX_LOG) : log2;
        span  = ((IW+1)'(1) << n_eff) - (IW+1)'(1);
        idx_d = idx_q;
        if (adv) idx_d = (idx_q + IW'(1)) & span[IW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    assign idx = idx_q & span[IW-1:0];
endmodule

// File: rtl/rxr_lanes.sv
module rxr_lanes (
    input  logic [15:0] woff,
    input  logic [1:0]  lane,
    input  logic [15:0] cap,
    output logic [3:0]  be
);
    for (genvar k = 0; k < 4; k++) begin : g_lane
        assign be[k] = (2'(k) <= lane) && (({1'b0, woff} + 17'(k)) < {1'b0, cap});
    end
endmodule

// File: rtl/rx_ring_engine.sv
module rx_ring_engine
    import rxr_pkg::*;
#(
    parameter int AW      = 32,
    parameter int MAX_LOG = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ring_base,
    input  logic [3:0]    ring_log2,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_last,
    input  logic          rx_crc_bad,
    input  logic          rx_fram_bad,
    output logic          rx_ready,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    output logic [3:0]    mem_be,
    input  logic [31:0]   mem_rdata,
    output logic          rx_int,
    output logic          rx_missed
);
    localparam int ENT_SHIFT = 4;

    typedef struct packed {
        rxr_state_e    st;
        logic [AW-1:0] ent;
        logic [AW-1:0] bufa;
        logic [15:0]   cap;
        logic [15:0]   capfld;
        logic [15:0]   cnt;
        logic [31:0]   wbuf;
        logic          crc;
        logic          fram;
        logic          oflo;
    } regs_t;

    regs_t r_d, r_q;

    logic [MAX_LOG-1:0] idx;
    logic [AW-1:0]      ent_now;
    logic               adv;
    logic [3:0]         lane_be;
    logic [31:0]        wb;
    logic [31:0]        stat_word;

    rxr_index #(.MAX_LOG(MAX_LOG)) u_idx (
        .clk(clk), .rst_n(rst_n), .adv(adv), .log2(ring_log2), .idx(idx)
    );

    rxr_lanes u_lanes (
        .woff({r_q.cnt[15:2], 2'b00}), .lane(r_q.cnt[1:0]), .cap(r_q.cap), .be(lane_be)
    );

    assign ent_now = ring_base + (AW'(idx) << ENT_SHIFT);

    always_comb begin
        stat_word           = '0;
        stat_word[15:0]     = r_q.capfld;
        stat_word[STP_BIT]  = 1'b1;
        stat_word[ENP_BIT]  = 1'b1;
        stat_word[CRC_BIT]  = r_q.crc;
        stat_word[OFLO_BIT] = r_q.oflo;
        stat_word[FRAM_BIT] = r_q.fram;
        stat_word[BUFE_BIT] = 1'b0;
        stat_word[ERR_BIT]  = r_q.crc | r_q.oflo | r_q.fram;
        stat_word[OWN_BIT]  = 1'b0;
    end

    always_comb begin
        r_d       = r_q;
        rx_ready  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = r_q.ent;
        mem_wdata = '0;
        mem_be    = 4'h0;
        rx_int    = 1'b0;
        rx_missed = 1'b0;
        adv       = 1'b0;
        wb        = r_q.wbuf;
        wb[8*r_q.cnt[1:0] +: 8] = rx_data;
        unique case (r_q.st)
            S_IDLE: begin
                if (rx_valid) begin
                    mem_req  = 1'b1;
                    mem_addr = ent_now + AW'(4);
                    r_d.ent  = ent_now;
                    r_d.st   = S_STAT_RD;
                end
            end
            S_STAT_RD: begin
                if (!mem_rdata[OWN_BIT]) begin
                    rx_missed = 1'b1;
                    r_d.st    = S_DROP;
                end else begin
                    mem_req    = 1'b1;
                    mem_addr   = r_q.ent;
                    r_d.cap    = 16'd0 - mem_rdata[15:0];
                    r_d.capfld = mem_rdata[15:0];
                    r_d.cnt    = '0;
                    r_d.oflo   = 1'b0;
                    r_d.st     = S_PTR_RD;
                end
            end
            S_PTR_RD: begin
                r_d.bufa = mem_rdata[AW-1:0];
                r_d.st   = S_DATA;
            end
            S_DATA: begin
                rx_ready = 1'b1;
                if (rx_valid) begin
                    r_d.wbuf = wb;
                    r_d.cnt  = r_q.cnt + 16'd1;
                    if (r_q.cnt >= r_q.cap) r_d.oflo = 1'b1;
                    if ((r_q.cnt[1:0] == 2'd3) || rx_last) begin
                        mem_req   = |lane_be;
                        mem_we    = 1'b1;
                        mem_addr  = r_q.bufa + AW'({r_q.cnt[15:2], 2'b00});
                        mem_wdata = wb;
                        mem_be    = lane_be;
                    end
                    if (rx_last) begin
                        r_d.crc  = rx_crc_bad;
                        r_d.fram = rx_fram_bad;
                        r_d.st   = S_LEN_WR;
                    end
                end
            end
            S_LEN_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = r_q.ent + AW'(8);
                mem_wdata = {20'd0, r_q.cnt[11:0]};
                mem_be    = 4'hF;
                r_d.st    = S_STAT_WR;
            end
            S_STAT_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = r_q.ent + AW'(4);
                mem_wdata = stat_word;
                mem_be    = 4'hF;
                rx_int    = 1'b1;
                adv       = 1'b1;
                r_d.st    = S_IDLE;
            end
            S_DROP: begin
                rx_ready = 1'b1;
                if (rx_valid && rx_last) r_d.st = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/rxr_checker.sv
module rxr_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          rx_int,
    input logic          rx_missed
);
    // R10
    int_with_stat_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_int |-> (mem_req && mem_we && mem_addr[3:0] == 4'h4));

    // R10
    int_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_int |=> !rx_int);

    // R8
    len_before_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_int |-> $past(mem_req && mem_we && mem_addr[3:0] == 4'h8));

    // R7
    stat_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_int |-> (!mem_wdata[31] && (mem_wdata[30] == (|mem_wdata[29:26]))
                    && mem_wdata[25] && mem_wdata[24]));

    // R3
    missed_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_missed |-> !mem_req);

    // R3
    missed_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_missed |=> !rx_missed);

    // R3
    missed_not_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_missed && rx_int));
endmodule

bind rx_ring_engine rxr_checker #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rx_int(rx_int), .rx_missed(rx_missed)
);

// File: tb/tb_rx_ring_engine.sv
module tb_rx_ring_engine;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int BUF0 = 32'h100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] ring_base = '0;
    logic [3:0] ring_log2 = 4'd2;
    logic rx_valid = 0, rx_last = 0, rx_crc_bad = 0, rx_fram_bad = 0;
    logic [7:0] rx_data = '0;
    logic rx_ready, mem_req, mem_we, rx_int, rx_missed;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic [3:0] mem_be;

    logic [31:0] mem [0:127];
    int tests = 0, fails = 0;
    int int_cnt = 0, miss_cnt = 0, order_bad = 0, other_req = 0;
    logic prev_len_wr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_ring_engine #(.AW(AW), .MAX_LOG(7)) dut (
        .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .ring_log2(ring_log2),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .rx_crc_bad(rx_crc_bad), .rx_fram_bad(rx_fram_bad), .rx_ready(rx_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_be(mem_be), .mem_rdata(mem_rdata), .rx_int(rx_int), .rx_missed(rx_missed)
    );

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                for (int k = 0; k < 4; k++)
                    if (mem_be[k]) mem[mem_addr[8:2]][8*k +: 8] <= mem_wdata[8*k +: 8];
            end else begin
                mem_rdata <= mem[mem_addr[8:2]];
            end
        end
        if (rst_n) begin
            if (rx_int) int_cnt <= int_cnt + 1;
            if (rx_missed) miss_cnt <= miss_cnt + 1;
            if (mem_req && mem_we && mem_addr < BUF0 && mem_addr[3:0] == 4'h4 && !prev_len_wr)
                order_bad <= order_bad + 1;
        end
        prev_len_wr <= mem_req && mem_we && mem_addr < BUF0 && mem_addr[3:0] == 4'h8;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] rdbyte(input int a);
        return mem[a >> 2][8*(a % 4) +: 8];
    endfunction

    function automatic logic [7:0] pat(input int f, input int i);
        return 8'(f * 16 + i + 1);
    endfunction

    task automatic setup_entry(input int e, input int cap, input logic own);
        int b;
        b = BUF0 + e * 64;
        mem[e*4 + 0] = 32'(b);
        mem[e*4 + 1] = {own, 15'd0, 16'(-cap)};
        mem[e*4 + 2] = 32'hDEAD_0BAD;
        for (int w = 0; w < 16; w++) mem[b/4 + w] = 32'hA5A5_A5A5;
    endtask

    task automatic send_frame(input int len, input int f, input logic crc, input logic fram);
        for (int i = 0; i < len; i++) begin
            rx_valid = 1; rx_data = pat(f, i); rx_last = (i == len - 1);
            rx_crc_bad = crc; rx_fram_bad = fram;
            while (!rx_ready) @(negedge clk);
            @(negedge clk);
        end
        rx_valid = 0; rx_last = 0; rx_crc_bad = 0; rx_fram_bad = 0;
        repeat (4) @(negedge clk);
    endtask

    task automatic check_frame(input int e, input int len, input int cap, input int f,
                               input logic crc, input logic fram);
        int b, lim, bad;
        logic oflo;
        logic [31:0] es;
        b = BUF0 + e * 64;
        oflo = len > cap;
        es = {1'b0, crc | fram | oflo, fram, oflo, crc, 1'b0, 2'b11, 8'h00, 16'(-cap)};
        chk($sformatf("R7 R5 status e%0d len%0d cap%0d", e, len, cap), mem[e*4+1], es);
        chk($sformatf("R6 length e%0d len%0d", e, len), mem[e*4+2], 32'(len));
        lim = (len < cap) ? len : cap;
        bad = 0;
        for (int i = 0; i < 16; i++) begin
            if (i < lim) begin
                if (rdbyte(b + i) !== pat(f, i)) bad++;
            end else if (rdbyte(b + i) !== 8'hA5) bad++;
        end
        chk($sformatf("R4 R2 buffer bytes e%0d len%0d cap%0d", e, len, cap), 32'(bad), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int e, f, ints0, miss0;
        logic crc, fram;
        for (int w = 0; w < 128; w++) mem[w] = 32'h0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset mem_req", 32'(mem_req), 0);
        chk("R1 reset rx_ready", 32'(rx_ready), 0);
        chk("R1 reset pulses", {30'd0, rx_int, rx_missed}, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 idle no request", 32'(mem_req), 0);

        // R9 ring of 4: sweep capacities and lengths
        e = 0; f = 0;
        for (int ci = 0; ci < 2; ci++) begin
            for (int len = 1; len <= 12; len++) begin
                int cap;
                cap = (ci == 0) ? 5 : 8;
                crc = (f % 3 == 1); fram = (f % 5 == 2);
                setup_entry(e, cap, 1'b1);
                ints0 = int_cnt;
                send_frame(len, f, crc, fram);
                check_frame(e, len, cap, f, crc, fram);
                chk($sformatf("R10 one pulse frame %0d", f), 32'(int_cnt - ints0), 1);
                e = (e + 1) % 4; f++;
            end
        end
        chk("R3 no missed in sweep", 32'(miss_cnt), 0);

        // R3 entry not owned
        setup_entry(e, 8, 1'b0);
        ints0 = int_cnt; miss0 = miss_cnt;
        send_frame(6, f, 1'b0, 1'b0);
        chk("R3 missed pulse", 32'(miss_cnt - miss0), 1);
        chk("R3 no int on drop", 32'(int_cnt - ints0), 0);
        chk("R3 status untouched", mem[e*4+1], {16'h0000, 16'(-8)});
        chk("R3 length untouched", mem[e*4+2], 32'hDEAD_0BAD);
        chk("R3 buffer untouched", mem[(BUF0 + e*64)/4], 32'hA5A5_A5A5);
        // R3 same entry used next
        setup_entry(e, 8, 1'b1);
        send_frame(7, f, 1'b1, 1'b1);
        check_frame(e, 7, 8, f, 1'b1, 1'b1);
        f++;

        // R9 two-entry ring after a fresh reset
        @(negedge clk); rst_n = 0; ring_log2 = 4'd1;
        repeat (2) @(negedge clk);
        chk("R1 second reset rx_ready", 32'(rx_ready), 0);
        rst_n = 1; @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            int ex;
            ex = k % 2;
            setup_entry(0, 8, 1'b1);
            setup_entry(1, 8, 1'b1);
            setup_entry(2, 8, 1'b1);
            send_frame(4, f, 1'b0, 1'b0);
            chk($sformatf("R9 wrap frame %0d own entry%0d", k, ex), 32'(mem[ex*4+1][31]), 0);
            chk($sformatf("R9 wrap frame %0d other entry", k), 32'(mem[(1-ex)*4+1][31]), 1);
            chk($sformatf("R9 wrap frame %0d entry2 idle", k), mem[2*4+1][31:0], {16'h8000, 16'(-8)});
            f++;
        end

        // R8 ordering seen on the port
        chk("R8 length write precedes status", 32'(order_bad), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule